// File: doc/BRIEF.md
# Auto-Increment Indirect Memory Window

This block gives a register bus a two-register window onto a word-organised local RAM. One register, the pointer, holds a byte offset into a 16 MiB address space together with two stepping modes. The other, the data port, reads or writes the 32-bit word that the pointer addresses. Software sets the start offset and the mode once and then streams successive words through the data port. The pointer steps by one word after each access in the enabled direction.

Read and write stepping have separate enables. A pointer set up for a write burst therefore stays put on data-port reads, and the reverse holds too. The backing RAM is internal and much smaller than the 16 MiB window. Accesses past its end are harmless: writes are dropped, reads give zero, and the pointer keeps stepping.

Read data appears on the bus one cycle after the read strobe and holds until the next accepted read. When both strobes are high in the same cycle, the write is performed and the read is ignored. Within each word, byte addresses map little-endian: the lowest byte address sits in bits 7:0.

Top module: `mem_window`

## Requirements
- R1: After reset, the pointer register reads 0x0000_0000: offset zero, both stepping modes off.
- R2: The pointer register is at bus address 0xAC0. Bits 23:0 hold the byte offset, bit 24 enables stepping on writes and bit 25 enables stepping on reads. Offset bits 1:0 are dropped on write, and bits 1:0 and 31:26 read back as zero. Reading the pointer returns the live offset and both mode bits.
- R3: A write to the data port at bus address 0xAC4 stores the 32-bit word at word index offset/4. A data-port read returns the word at the current offset on bus_rdata in the cycle after the read strobe.
- R4: With bit 24 set, each data-port write advances the offset by 4 after the write.
- R5: With bit 25 set, each data-port read advances the offset by 4. The read itself returns the word at the offset held before the step.
- R6: When the stepping bit for an access direction is clear, that access leaves the offset unchanged, so repeated accesses hit the same word.
- R7: When the word index is at or beyond the RAM depth, a data-port write changes no stored word and a data-port read returns zero. The offset still steps as R4 and R5 describe.
- R8: The offset is 24 bits wide and wraps from 0xFFFFFC to 0x000000 on a step.
- R9: Writes to any other bus address have no effect, and reads of any other bus address return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after an accepted read |

## Verification
A pointer that steps wrongly, fails to step or holds when it should not shows up within a few accesses. It appears either as the wrong word on the next data-port read or as an unexpected offset on the next pointer read. Both are visible one cycle after the read strobe. A range check that is off, or a RAM address that is truncated without a range check, shows up as nonzero data for an out-of-range read or as a corrupted low word. The bench guards against the truncation case by checking a low word after a burst that crosses the RAM end.

// File: rtl/idx_window_pkg.sv
package idx_window_pkg;

    parameter int BUS_AW   = 12;
    parameter int DATA_W   = 32;
    parameter int OFF_W    = 24;
    parameter int WIDX_W   = OFF_W - 2;

    parameter logic [BUS_AW-1:0] PTR_ADDR  = 12'hAC0;
    parameter logic [BUS_AW-1:0] PORT_ADDR = 12'hAC4;

    parameter int WR_STEP_BIT = 24;
    parameter int RD_STEP_BIT = 25;

    typedef struct packed {
        logic             rd_step;
        logic             wr_step;
        logic [OFF_W-1:0] off;
    } ptr_t;

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_PTR  = 2'd1,
        RK_MEM  = 2'd2
    } rd_kind_t;

    function automatic ptr_t ptr_from_bus(input logic [DATA_W-1:0] w);
        ptr_t p;
        p.rd_step = w[RD_STEP_BIT];
        p.wr_step = w[WR_STEP_BIT];
        p.off     = {w[OFF_W-1:2], 2'b00};
        return p;
    endfunction

    function automatic logic [DATA_W-1:0] ptr_to_bus(input ptr_t p);
        return {{(DATA_W-OFF_W-2){1'b0}}, p};
    endfunction

endpackage

// File: rtl/idx_ptr_reg.sv
module idx_ptr_reg
    import idx_window_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              step,
    output ptr_t              ptr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= ptr_from_bus(load_val);
        end else if (step) begin
            ptr.off <= ptr.off + OFF_W'(4);
        end
    end

endmodule

// File: rtl/idx_word_ram.sv
module idx_word_ram #(
    parameter int DEPTH = 256,
    parameter int WIDTH = 32,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic             re,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        if (re) begin
            q <= mem[addr];
        end
    end

endmodule

// File: rtl/mem_window.sv
module mem_window
    import idx_window_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [11:0]       bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);

    localparam logic [WIDX_W-1:0] DEPTH_IDX = WIDX_W'(DEPTH);

    ptr_t              ptr_q;
    logic              hit_ptr, hit_port;
    logic              rd_ok;
    logic              in_range;
    logic [WIDX_W-1:0] widx;
    logic              step;
    logic [DATA_W-1:0] ram_q;
    rd_kind_t          kind_q;
    logic [DATA_W-1:0] snap_q;

    // Flat views of the pointer for the bound checker.
    logic [OFF_W-1:0]  cur_off;
    logic              cur_wr_step;
    logic              cur_rd_step;

    assign cur_off     = ptr_q.off;
    assign cur_wr_step = ptr_q.wr_step;
    assign cur_rd_step = ptr_q.rd_step;

    always_comb begin
        hit_ptr  = (bus_addr == PTR_ADDR);
        hit_port = (bus_addr == PORT_ADDR);
        rd_ok    = bus_rd && !bus_wr;
        widx     = ptr_q.off[OFF_W-1:2];
        in_range = (widx < DEPTH_IDX);
        step     = hit_port && ((bus_wr && ptr_q.wr_step) ||
                                (rd_ok  && ptr_q.rd_step));
    end

    idx_ptr_reg u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (bus_wr && hit_ptr),
        .load_val (bus_wdata),
        .step     (step),
        .ptr      (ptr_q)
    );

    idx_word_ram #(
        .DEPTH (DEPTH),
        .WIDTH (DATA_W)
    ) u_ram (
        .clk   (clk),
        .we    (bus_wr && hit_port && in_range),
        .re    (rd_ok && hit_port && in_range),
        .addr  (widx[AW-1:0]),
        .wdata (bus_wdata),
        .q     (ram_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= RK_NONE;
            snap_q <= '0;
        end else if (rd_ok) begin
            snap_q <= ptr_to_bus(ptr_q);
            if (hit_ptr) begin
                kind_q <= RK_PTR;
            end else if (hit_port && in_range) begin
                kind_q <= RK_MEM;
            end else begin
                kind_q <= RK_NONE;
            end
        end
    end

    always_comb begin
        unique case (kind_q)
            RK_PTR:  bus_rdata = snap_q;
            RK_MEM:  bus_rdata = ram_q;
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/idx_window_chk.sv
module idx_window_chk
    import idx_window_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input logic             clk,
    input logic             rst,
    input logic [11:0]      bus_addr,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [31:0]      bus_rdata,
    input logic [OFF_W-1:0] off,
    input logic             wr_step,
    input logic             rd_step
);

    logic port_wr, port_rd, ptr_rd, oor;
    assign port_wr = bus_wr && (bus_addr == PORT_ADDR);
    assign port_rd = bus_rd && !bus_wr && (bus_addr == PORT_ADDR);
    assign ptr_rd  = bus_rd && !bus_wr && (bus_addr == PTR_ADDR);
    assign oor     = ({2'b00, off[OFF_W-1:2]} >= 24'(DEPTH));

    a_r2_aligned: assert property (@(posedge clk) disable iff (rst)
        off[1:0] == 2'b00);

    a_r2_ptr_readback: assert property (@(posedge clk) disable iff (rst)
        ptr_rd |=> bus_rdata == {6'b0, $past(rd_step), $past(wr_step), $past(off)});

    a_r4_write_step: assert property (@(posedge clk) disable iff (rst)
        (port_wr && wr_step) |=> off == $past(off) + 24'd4);

    a_r5_read_step: assert property (@(posedge clk) disable iff (rst)
        (port_rd && rd_step) |=> off == $past(off) + 24'd4);

    a_r6_write_hold: assert property (@(posedge clk) disable iff (rst)
        (port_wr && !wr_step) |=> $stable(off));

    a_r6_read_hold: assert property (@(posedge clk) disable iff (rst)
        (port_rd && !rd_step) |=> $stable(off));

    a_r7_oor_zero: assert property (@(posedge clk) disable iff (rst)
        (port_rd && oor) |=> bus_rdata == 32'd0);

endmodule

bind mem_window idx_window_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .off       (cur_off),
    .wr_step   (cur_wr_step),
    .rd_step   (cur_rd_step)
);

// File: tb/mem_window_test.sv
module mem_window_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] PTR  = 12'hAC0;
    localparam logic [11:0] PORT = 12'hAC4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    mem_window uut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(PTR, v);
        check("R1 reset pointer", v, 32'h0);
    endtask

    task automatic t_pointer();
        logic [31:0] v;
        wr(PTR, 32'hFFFF_FFFF);
        rd(PTR, v);
        check("R2 all ones readback", v, 32'h03FF_FFFC);
        wr(PTR, 32'h0000_0013);
        rd(PTR, v);
        check("R2 low bits dropped", v, 32'h0000_0010);
    endtask

    task automatic t_bursts();
        logic [31:0] v;
        wr(PTR, 32'h0100_0010);
        for (int i = 0; i < 4; i++) wr(PORT, 32'hA0A0_0000 + i);
        rd(PTR, v);
        check("R4 write burst offset", v, 32'h0100_0020);
        wr(PTR, 32'h0200_0010);
        for (int i = 0; i < 4; i++) begin
            rd(PORT, v);
            check("R3 R5 read burst word", v, 32'hA0A0_0000 + i);
        end
        rd(PTR, v);
        check("R5 read burst offset", v, 32'h0200_0020);
    endtask

    task automatic t_hold();
        logic [31:0] v;
        wr(PTR, 32'h0000_0040);
        wr(PORT, 32'h1234_5678);
        wr(PORT, 32'hCAFE_F00D);
        rd(PTR, v);
        check("R6 write hold offset", v, 32'h0000_0040);
        wr(PTR, 32'h0100_0040);
        rd(PORT, v);
        check("R6 repeat read 1", v, 32'hCAFE_F00D);
        rd(PORT, v);
        check("R6 repeat read 2", v, 32'hCAFE_F00D);
        rd(PTR, v);
        check("R6 read hold with write step", v, 32'h0100_0040);
    endtask

    task automatic t_out_of_range();
        logic [31:0] v;
        wr(PTR, 32'h0000_0000);
        wr(PORT, 32'h0000_1111);
        wr(PTR, 32'h0100_03FC);
        wr(PORT, 32'h5555_00FF);
        wr(PORT, 32'h9999_9999);
        rd(PTR, v);
        check("R7 offset steps past end", v, 32'h0100_0404);
        wr(PTR, 32'h0200_03FC);
        rd(PORT, v);
        check("R7 last word", v, 32'h5555_00FF);
        rd(PORT, v);
        check("R7 out of range reads zero", v, 32'h0);
        rd(PTR, v);
        check("R7 read offset steps", v, 32'h0200_0404);
        wr(PTR, 32'h0000_0000);
        rd(PORT, v);
        check("R7 low word not aliased", v, 32'h0000_1111);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        wr(PTR, 32'h01FF_FFFC);
        wr(PORT, 32'h7777_7777);
        rd(PTR, v);
        check("R8 offset wraps", v, 32'h0100_0000);
        rd(PORT, v);
        check("R8 word zero after wrap", v, 32'h0000_1111);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(PTR, 32'h0200_0010);
        wr(12'hAC8, 32'hDEAD_BEEF);
        rd(PTR, v);
        check("R9 pointer untouched", v, 32'h0200_0010);
        rd(12'hAC8, v);
        check("R9 unmapped reads zero", v, 32'h0);
        rd(PORT, v);
        check("R9 memory untouched", v, 32'hA0A0_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_pointer();
        t_bursts();
        t_hold();
        t_out_of_range();
        t_wrap();
        t_unmapped();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule